// File: doc/BRIEF.md
# Byte-to-Word Boot ROM Read Bridge

This block connects an 8-bit boot ROM to a 32-bit processor data bus during start-up. After power-up it keeps the processor in reset. It also keeps every pad it would drive switched off until a configuration-done input arrives. That input is brought into the clock domain through two flops. Once the block sees it, the processor is released and the ROM pads are enabled.

The processor then reads ROM words to copy its code into wider RAM. For each read, the block walks the low two ROM address bits through four byte cycles. It stores the first three bytes in registers that drive the lower 24 data bits. The fourth byte is not registered: the ROM data pins are wired straight onto the top byte lane. The read is acknowledged in the last clock of that fourth byte cycle.

Each byte cycle lasts a parameter number of clocks, to cover the ROM access time. Drive-enable outputs tell the pad ring when the processor-side and ROM-side pins may leave high impedance.

Top module: `boot_rom_word_bridge`

## Requirements
- R1: While the synchronised configuration-done state is false, cpu_rst_n is 0, bus_oe is 0, data_oe is 0, rom_oe_n is 1 and cpu_ack is 0, whatever cpu_cs does.
- R2: cpu_rst_n rises in the second clock after the first clock edge that samples cfg_done high, and stays high until rst_n, even if cfg_done falls again.
- R3: A word read presents the ROM addresses {cpu_addr, 2'b00}, {cpu_addr, 2'b01}, {cpu_addr, 2'b10}, {cpu_addr, 2'b11} in that order. The word address forms the upper bits and the byte counter forms bits 1..0.
- R4: Lane mapping is fixed: the byte at ROM offset 0 goes to cpu_data[7:0], offset 1 to [15:8], offset 2 to [23:16] and offset 3 to [31:24].
- R5: Each byte cycle lasts WAIT_CLKS clocks. cpu_ack is high in the 4*WAIT_CLKS-th clock after the edge that first samples cpu_cs high with the processor released.
- R6: cpu_ack is high for exactly one clock per read. In that clock cpu_data[31:24] equals the live ROM byte, so the full 32-bit word is valid.
- R7: After cpu_ack, cpu_data[23:0] keeps the staged bytes while cpu_cs stays high. data_oe equals released AND cpu_cs.
- R8: Dropping cpu_cs during a read, including in the acknowledge clock itself, ends the read at the next edge. A later assertion of cpu_cs starts a fresh, correct read.
- R9: rom_oe_n is 0 exactly during the byte cycles of a read and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_done | input | 1 | Configuration finished (asynchronous) |
| cpu_rst_n | output | 1 | Active-low reset to the processor |
| cpu_cs | input | 1 | Processor read select for the ROM window |
| cpu_addr | input | AW | Processor word address |
| cpu_ack | output | 1 | Read acknowledge, one clock |
| cpu_data | output | 32 | Read word; bits 31..24 are the ROM pins |
| data_oe | output | 1 | Drive enable for the processor data pads |
| rom_addr | output | AW+2 | ROM byte address |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_data | input | 8 | ROM data pins |
| bus_oe | output | 1 | Drive enable for the ROM address and strobe pads |

## Verification
Two events can fall in the same clock, and the bench provokes each pairing on purpose.

The first pairing is the end of reset hold and a pending read. cpu_cs is held high through the whole hold period, and cfg_done is then raised. The bench checks three things: no ROM strobe before release, release after exactly two clocks, and a correct word read that starts on the first released edge.

The second pairing is the acknowledge clock and the removal of select. cpu_cs is dropped at the very sample where cpu_ack is seen. The bench then judges two outcomes: the ROM strobe must be gone one clock later, and the next read, to a different address, must return its own word with the nominal latency.

// File: rtl/boot_rom_word_bridge.sv
module boot_rom_word_bridge #(
  parameter int AW        = 14,
  parameter int WAIT_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_done,
  output logic          cpu_rst_n,
  input  logic          cpu_cs,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_ack,
  output logic [31:0]   cpu_data,
  output logic          data_oe,
  output logic [AW+1:0] rom_addr,
  output logic          rom_oe_n,
  input  logic [7:0]    rom_data,
  output logic          bus_oe
);

  localparam int WW    = (WAIT_CLKS < 2) ? 1 : $clog2(WAIT_CLKS);
  localparam int WLAST = WAIT_CLKS - 1;

  typedef enum logic [1:0] {S_IDLE, S_BYTE, S_DONE} st_t;

  logic          cfg_s1, cfg_s2;
  st_t           state;
  logic [1:0]    idx;
  logic [WW-1:0] wcnt;
  logic [23:0]   stage;
  logic          byte_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_s1 <= 1'b0;
      cfg_s2 <= 1'b0;
    end else begin
      cfg_s1 <= cfg_s1 | cfg_done;
      cfg_s2 <= cfg_s1;
    end
  end

  assign byte_last = (state == S_BYTE) && (wcnt == WW'(WLAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= 2'd0;
      wcnt  <= '0;
      stage <= '0;
    end else begin
      case (state)
        S_IDLE: if (cfg_s2 && cpu_cs) begin
          state <= S_BYTE;
          idx   <= 2'd0;
          wcnt  <= '0;
        end
        S_BYTE: begin
          if (!cpu_cs) begin
            state <= S_IDLE;
          end else if (byte_last) begin
            wcnt <= '0;
            if (idx == 2'd3) begin
              state <= S_DONE;
            end else begin
              for (int i = 0; i < 3; i++)
                if (idx == 2'(i)) stage[i*8 +: 8] <= rom_data;
              idx <= idx + 2'd1;
            end
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        default: if (!cpu_cs) state <= S_IDLE;
      endcase
    end
  end

  assign cpu_rst_n = cfg_s2;
  assign bus_oe    = cfg_s2;
  assign data_oe   = cfg_s2 && cpu_cs;
  assign rom_oe_n  = (state != S_BYTE);
  assign rom_addr  = {cpu_addr, idx};
  assign cpu_ack   = byte_last && (idx == 2'd3) && cpu_cs;
  assign cpu_data  = {rom_data, stage};

  p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst_n |-> (rom_oe_n && !cpu_ack && !data_oe && !bus_oe));

  p_release_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(cfg_done, 2));

  p_release_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cpu_rst_n));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_last && idx != 2'd3 && cpu_cs) |=> (rom_addr[1:0] == $past(rom_addr[1:0]) + 2'd1));

  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_oe_n && $past(!rom_oe_n && !byte_last) && $stable(cpu_addr)) |-> $stable(rom_addr));

  p_ack_lastbyte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (rom_addr[1:0] == 2'd3 && !rom_oe_n));

  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  p_hold_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_ack) && cpu_cs) |-> $stable(cpu_data[23:0]));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_oe_n && !cpu_cs) |=> rom_oe_n);

endmodule

// File: tb/boot_rom_word_bridge_tb_top.sv
`timescale 1ns/1ps
module boot_rom_word_bridge_tb_top;
  localparam int AW = 14;
  localparam int WC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_done = 1'b0;
  logic cpu_cs = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_rst_n, cpu_ack, data_oe, rom_oe_n, bus_oe;
  logic [31:0] cpu_data;
  logic [AW+1:0] rom_addr;
  logic [7:0] rom_data;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [AW+1:0] a);
    return (a[7:0] * 8'd7) ^ {a[15:10], 2'b01} ^ 8'h3C;
  endfunction

  function automatic logic [31:0] word_of(input logic [AW-1:0] w);
    return {rom_byte({w, 2'd3}), rom_byte({w, 2'd2}), rom_byte({w, 2'd1}), rom_byte({w, 2'd0})};
  endfunction

  assign rom_data = rom_byte(rom_addr);

  boot_rom_word_bridge #(.AW(AW), .WAIT_CLKS(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .cpu_rst_n(cpu_rst_n),
    .cpu_cs(cpu_cs), .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .cpu_data(cpu_data),
    .data_oe(data_oe), .rom_addr(rom_addr), .rom_oe_n(rom_oe_n),
    .rom_data(rom_data), .bus_oe(bus_oe));

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Waits for ack counting negedges from now; checks R3, R4, R5, R6, R9.
  task automatic wait_word(input logic [AW-1:0] w, input bit drop_at_ack);
    int n = 0;
    int bad_addr = 0;
    int bad_oe = 0;
    logic [31:0] got;
    while (1) begin
      @(negedge clk);
      n++;
      if (cpu_ack) break;
      if (n > 60) break;
      if (rom_oe_n !== 1'b0) bad_oe++;
      if (rom_addr !== {w, 2'((n - 1) / WC)}) bad_addr++;
    end
    check("R5", "ack latency", 32'(n), 32'(4 * WC));
    check("R3", "byte address order mismatches", 32'(bad_addr), 32'd0);
    check("R9", "strobe off during byte cycles", 32'(bad_oe), 32'd0);
    got = cpu_data;
    check("R4", "word lanes", got, word_of(w));
    check("R6", "top lane is live rom byte", 32'(cpu_data[31:24]), 32'(rom_data));
    if (drop_at_ack) begin
      cpu_cs = 1'b0;
      @(negedge clk);
      check("R8", "strobe off after drop at ack", 32'(rom_oe_n), 32'd1);
      check("R6", "ack gone", 32'(cpu_ack), 32'd0);
    end else begin
      @(negedge clk);
      check("R6", "ack one clock", 32'(cpu_ack), 32'd0);
      check("R9", "strobe off after word", 32'(rom_oe_n), 32'd1);
      @(negedge clk);
      check("R7", "lower lanes held", 32'(cpu_data[23:0]), 32'(got[23:0]));
      check("R7", "data_oe with cs", 32'(data_oe), 32'd1);
      cpu_cs = 1'b0;
      @(negedge clk);
      check("R7", "data_oe after cs drop", 32'(data_oe), 32'd0);
    end
  endtask

  task automatic t_reset_hold_then_release();
    int n = 0;
    int bad = 0;
    cpu_addr = 14'h0005;
    cpu_cs = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cpu_rst_n !== 1'b0 || bus_oe !== 1'b0 || data_oe !== 1'b0 ||
          rom_oe_n !== 1'b1 || cpu_ack !== 1'b0) bad++;
    end
    check("R1", "outputs quiet while held", 32'(bad), 32'd0);
    cfg_done = 1'b1;
    while (cpu_rst_n !== 1'b1 && n < 20) begin
      @(negedge clk);
      n++;
      if (cpu_rst_n !== 1'b1 && rom_oe_n !== 1'b1) bad++;
    end
    check("R2", "release delay", 32'(n), 32'd2);
    check("R1", "no strobe before release", 32'(bad), 32'd0);
    check("R1", "bus_oe at release", 32'(bus_oe), 32'd1);
    wait_word(14'h0005, 1'b0);
  endtask

  task automatic t_read(input logic [AW-1:0] w);
    cpu_addr = w;
    cpu_cs = 1'b1;
    wait_word(w, 1'b0);
  endtask

  task automatic t_abort();
    cpu_addr = 14'h0101;
    cpu_cs = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "strobe active mid read", 32'(rom_oe_n), 32'd0);
    cpu_cs = 1'b0;
    @(negedge clk);
    check("R8", "strobe off after abort", 32'(rom_oe_n), 32'd1);
    check("R8", "no ack after abort", 32'(cpu_ack), 32'd0);
    t_read(14'h0102);
  endtask

  task automatic t_drop_at_ack();
    cpu_addr = 14'h1234;
    cpu_cs = 1'b1;
    wait_word(14'h1234, 1'b1);
    t_read(14'h0ABC);
  endtask

  task automatic t_sticky_release();
    cfg_done = 1'b0;
    repeat (4) @(negedge clk);
    check("R2", "release stays after cfg_done low", 32'(cpu_rst_n), 32'd1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset state cpu_rst_n", 32'(cpu_rst_n), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_hold_then_release();
    t_read(14'h0000);
    t_read(14'h3FFF);
    t_read(14'h2A55);
    t_abort();
    t_drop_at_ack();
    t_sticky_release();
    t_read(14'h0007);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule